// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects interrupt requests from eight maskable devices and one non-maskable line. It selects the most urgent request that may be raised, drives a single request line to the processor, and presents a 4-bit vector code that names the winning source. When the processor acknowledges, the controller records the level it interrupts, raises the current level to that of the granted source, and clears the global enable. Service routines can therefore nest, but only above the running priority.

A small register port sets the per-source enable bits and the global enable. It also lets software pend any maskable source, as if the device had asked. An end-of-service strobe returns the controller to the level it interrupted and turns the global enable back on. The saved-level stack holds four entries. While it is full, no further request is raised.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `gie_o` is 0, `err_o` is 0 and `cur_lvl_o` is 9 (idle, below every source).
- R2: A maskable source whose enable bit (register select 0, bit i for source i) is 0 is never raised, even while its pending bit is set.
- R3: A rising edge on `nmi_i` latches a request that is raised regardless of the global enable and the enable bits. A line held high after that edge raises nothing more until it falls and rises again.
- R4: On an accepted acknowledge (`ack_i` high while `irq_o` is high), the global enable reads 0 in the next cycle.
- R5: Among raised candidates the lowest source index wins, and the non-maskable request outranks every maskable one.
- R6: `vec_o` is the source index (0 to 7) for a maskable winner and 4'hF for the non-maskable winner.
- R7: Levels are 0 for the non-maskable line and i+1 for source i, and a smaller level is more urgent. A request is raised only if its level is strictly below `cur_lvl_o`.
- R8: A maskable request is raised only while the global enable (register select 2, bit 0) is 1.
- R9: An accepted acknowledge pushes the old level, loads `cur_lvl_o` with the granted level and clears that source's pending bit.
- R10: `eoi_i` with saved levels pops one, restores `cur_lvl_o` and sets the global enable. With none saved, it changes no level and pulses `err_o` for one cycle.
- R11: While four levels are saved, `irq_o` stays 0.
- R12: Writing register select 1 with bit i set pends source i.
- R13: `ack_i` while `irq_o` is 0 changes neither the level nor the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_req_i | input | 8 | Device request lines, captured into pending bits |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enables, 1 software pend, 2 global enable |
| reg_wdata_i | input | 8 | Register write data |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-service strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 4 | Vector code of the current winner |
| cur_lvl_o | output | 4 | Current running priority level |
| gie_o | output | 1 | Global enable |
| err_o | output | 1 | Pulse on an end-of-service with nothing saved |

## Verification
The checker watches on every cycle that a raised request is enabled, permitted by the global enable when maskable, and strictly above the running level. It also checks that a full stack suppresses the request, that an acceptance loads the granted level and drops the global enable, and that an empty pop keeps the level and flags the error. The bench scenarios cover what the properties cannot follow: which pending source wins under mixed patterns, the edge-only behaviour of a held non-maskable line, a deferred lower-priority request that surfaces only after two returns, and the exact sequence of restored levels.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_SWPEND = 2'd1,
    SEL_GIE    = 2'd2
  } vic_sel_e;
endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] dev_req,
  input  logic [NSRC-1:0] sw_set,
  input  logic [NSRC-1:0] clr,
  input  logic            nmi_line,
  input  logic            nmi_clr,
  output logic [NSRC-1:0] pend,
  output logic            nmi_pend
);
  logic [NSRC-1:0] pend_q, pend_d;
  logic            nmi_pend_q, nmi_pend_d;
  logic            nmi_prev_q;
  logic            nmi_edge;

  always_comb begin
    nmi_edge   = nmi_line & ~nmi_prev_q;
    pend_d     = (pend_q & ~clr) | dev_req | sw_set;
    nmi_pend_d = (nmi_pend_q & ~nmi_clr) | nmi_edge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      nmi_pend_q <= 1'b0;
      nmi_prev_q <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      nmi_pend_q <= nmi_pend_d;
      nmi_prev_q <= nmi_line;
    end
  end

  assign pend     = pend_q;
  assign nmi_pend = nmi_pend_q;
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 4,
  parameter int LVL_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req,
  input  logic             nmi_req,
  output logic             any,
  output logic             is_nmi,
  output logic [IDX_W-1:0] idx,
  output logic [LVL_W-1:0] lvl,
  output logic [VEC_W-1:0] code
);
  always_comb begin
    any    = 1'b0;
    is_nmi = 1'b0;
    idx    = '0;
    lvl    = '0;
    code   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        lvl  = LVL_W'(i + 1);
        code = VEC_W'(i);
      end
    end
    if (nmi_req) begin
      any    = 1'b1;
      is_nmi = 1'b1;
      lvl    = '0;
      code   = '1;
    end
  end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack #(
  parameter int DEPTH = 4,
  parameter int LVL_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] din,
  output logic [LVL_W-1:0] top,
  output logic             full,
  output logic             empty
);
  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  always_comb begin
    wr_idx = cnt_q[IDX_W-1:0];
    rd_idx = IDX_W'(cnt_q - CNT_W'(1));
    cnt_d  = cnt_q;
    if (push)     cnt_d = cnt_q + CNT_W'(1);
    else if (pop) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 mem_q[g] <= '0;
        else if (push && wr_idx == IDX_W'(g))       mem_q[g] <= din;
      end
    end
  endgenerate

  assign top   = mem_q[rd_idx];
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl #(
  parameter int NSRC      = 8,
  parameter int VEC_W     = 4,
  parameter int STK_DEPTH = 4,
  localparam int LVL_W    = $clog2(NSRC + 2),
  localparam int IDX_W    = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  dev_req_i,
  input  logic             nmi_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_sel_i,
  input  logic [NSRC-1:0]  reg_wdata_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             gie_o,
  output logic             err_o
);
  import vic_pkg::*;

  localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NSRC + 1);

  logic [NSRC-1:0]  mask_q, mask_d;
  logic             gie_q, gie_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             err_q, err_d;

  logic [NSRC-1:0]  pend, sw_set, clr, req_ok;
  logic             nmi_pend, nmi_clr;
  logic             win_any, win_nmi;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl, stk_top;
  logic [VEC_W-1:0] win_code;
  logic             stk_full, stk_empty;
  logic             accept, pop_ok;
  logic             wr_mask, wr_sw, wr_gie;

  always_comb begin
    wr_mask = reg_wr_i && (reg_sel_i == SEL_ENABLE);
    wr_sw   = reg_wr_i && (reg_sel_i == SEL_SWPEND);
    wr_gie  = reg_wr_i && (reg_sel_i == SEL_GIE);
    sw_set  = wr_sw ? reg_wdata_i : '0;
    req_ok  = pend & mask_q & {NSRC{gie_q}};
  end

  vic_capture #(.NSRC(NSRC)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req_i),
    .sw_set   (sw_set),
    .clr      (clr),
    .nmi_line (nmi_i),
    .nmi_clr  (nmi_clr),
    .pend     (pend),
    .nmi_pend (nmi_pend)
  );

  vic_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_arbiter (
    .req     (req_ok),
    .nmi_req (nmi_pend),
    .any     (win_any),
    .is_nmi  (win_nmi),
    .idx     (win_idx),
    .lvl     (win_lvl),
    .code    (win_code)
  );

  always_comb begin
    irq_o   = win_any && (win_lvl < lvl_q) && !stk_full;
    accept  = ack_i && irq_o;
    pop_ok  = eoi_i && !accept && !stk_empty;
    nmi_clr = accept && win_nmi;
    clr     = (accept && !win_nmi) ? (NSRC'(1) << win_idx) : '0;
  end

  vic_level_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .pop   (pop_ok),
    .din   (lvl_q),
    .top   (stk_top),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_comb begin
    mask_d = wr_mask ? reg_wdata_i : mask_q;
    lvl_d  = lvl_q;
    gie_d  = gie_q;
    err_d  = eoi_i && !accept && stk_empty;
    if (wr_gie) gie_d = reg_wdata_i[0];
    if (accept) begin
      lvl_d = win_lvl;
      gie_d = 1'b0;
    end else if (pop_ok) begin
      lvl_d = stk_top;
      gie_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
      lvl_q  <= IDLE_LVL;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      gie_q  <= gie_d;
      lvl_q  <= lvl_d;
      err_q  <= err_d;
    end
  end

  assign vec_o     = win_code;
  assign cur_lvl_o = lvl_q;
  assign gie_o     = gie_q;
  assign err_o     = err_q;
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NSRC  = 8,
  parameter int VEC_W = 4,
  parameter int LVL_W = 4,
  localparam int IDX_W = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [LVL_W-1:0] cur_lvl_o,
  input logic             gie_o,
  input logic             err_o,
  input logic             ack_i,
  input logic             eoi_i,
  input logic [NSRC-1:0]  mask_q,
  input logic             stk_full,
  input logic             stk_empty
);
  logic [LVL_W-1:0] vec_lvl;
  logic             vec_nmi;
  assign vec_nmi = (vec_o == '1);
  assign vec_lvl = vec_nmi ? '0 : LVL_W'(vec_o) + LVL_W'(1);

  // R2: a raised maskable source must be enabled
  a_r2_masked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !vec_nmi) |-> mask_q[vec_o[IDX_W-1:0]]);

  // R8: maskable request needs the global enable
  a_r8_gie_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !vec_nmi) |-> gie_o);

  // R7: only strictly more urgent levels are raised
  a_r7_strict_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_lvl < cur_lvl_o));

  // R4: acceptance drops the global enable
  a_r4_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> !gie_o);

  // R9: acceptance loads the granted level
  a_r9_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> (cur_lvl_o == $past(vec_lvl)));

  // R10: empty pop flags and keeps the level
  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && stk_empty && !(ack_i && irq_o)) |=> (err_o && $stable(cur_lvl_o)));

  // R11: full stack suppresses the request
  a_r11_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_o);

  // R13: acknowledge without a request changes nothing
  a_r13_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> $stable(cur_lvl_o));
endmodule

bind vic_irq_ctrl vic_checker #(.NSRC(NSRC), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_vic_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .cur_lvl_o (cur_lvl_o),
  .gie_o     (gie_o),
  .err_o     (err_o),
  .ack_i     (ack_i),
  .eoi_i     (eoi_i),
  .mask_q    (mask_q),
  .stk_full  (stk_full),
  .stk_empty (stk_empty)
);

// File: tb/vic_irq_ctrl_bench.sv
module vic_irq_ctrl_bench;
  import vic_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int NV         = 6;
  // entry: {enable[7:0], dev_req[7:0], gie, exp_irq, exp_vec[3:0]}
  localparam logic [21:0] TBL [NV] = '{
    {8'hFF, 8'h28, 1'b1, 1'b1, 4'd3},
    {8'hFF, 8'h81, 1'b1, 1'b1, 4'd0},
    {8'hF0, 8'h0F, 1'b1, 1'b0, 4'd0},
    {8'hFF, 8'h40, 1'b0, 1'b0, 4'd0},
    {8'hC0, 8'hC4, 1'b1, 1'b1, 4'd6},
    {8'hFF, 8'h80, 1'b1, 1'b1, 4'd7}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] dev_req_i;
  logic       nmi_i;
  logic       reg_wr_i;
  logic [1:0] reg_sel_i;
  logic [7:0] reg_wdata_i;
  logic       ack_i;
  logic       eoi_i;
  logic       irq_o;
  logic [3:0] vec_o;
  logic [3:0] cur_lvl_o;
  logic       gie_o;
  logic       err_o;

  int tests  = 0;
  int fails  = 0;
  int cycles = 0;

  vic_irq_ctrl u_vic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req_i(dev_req_i), .nmi_i(nmi_i),
    .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
    .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o), .vec_o(vec_o),
    .cur_lvl_o(cur_lvl_o), .gie_o(gie_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected < %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests = tests + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; dev_req_i = '0; nmi_i = 1'b0; reg_wr_i = 1'b0;
    reg_sel_i = '0; reg_wdata_i = '0; ack_i = 1'b0; eoi_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input vic_sel_e sel, input logic [7:0] data);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic pulse_req(input logic [7:0] v);
    dev_req_i = v;
    @(negedge clk);
    dev_req_i = '0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1;
    @(negedge clk);
    eoi_i = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 irq", irq_o, 0);
    chk("R1 gie", gie_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 level", cur_lvl_o, 9);

    // table walk: R2, R5, R6, R8, R9, R4
    for (int k = 0; k < NV; k++) begin
      do_reset();
      wr(SEL_ENABLE, TBL[k][21:14]);
      wr(SEL_GIE, {7'd0, TBL[k][5]});
      pulse_req(TBL[k][13:6]);
      chk("R2/R5/R8 irq", irq_o, int'(TBL[k][4]));
      if (TBL[k][4]) begin
        chk("R5/R6 vec", vec_o, int'(TBL[k][3:0]));
        do_ack();
        chk("R9 level", cur_lvl_o, int'(TBL[k][3:0]) + 1);
        chk("R4 gie", gie_o, 0);
      end
    end

    // R3 / R6: edge-only non-maskable line
    do_reset();
    nmi_i = 1'b1;
    @(negedge clk);
    chk("R3 nmi raised", irq_o, 1);
    chk("R6 nmi code", vec_o, 15);
    do_ack();
    chk("R9 nmi level", cur_lvl_o, 0);
    do_eoi();
    chk("R10 restore", cur_lvl_o, 9);
    chk("R10 gie set", gie_o, 1);
    @(negedge clk);
    chk("R3 held line", irq_o, 0);
    nmi_i = 1'b0;
    @(negedge clk);
    nmi_i = 1'b1;
    @(negedge clk);
    chk("R3 new edge", irq_o, 1);
    // R5: non-maskable outranks source 0
    wr(SEL_ENABLE, 8'hFF);
    pulse_req(8'h01);
    chk("R5 nmi first", vec_o, 15);

    // R7 nesting
    do_reset();
    wr(SEL_ENABLE, 8'hFF);
    wr(SEL_GIE, 8'h01);
    pulse_req(8'h10);
    do_ack();
    chk("R7 level src4", cur_lvl_o, 5);
    wr(SEL_GIE, 8'h01);
    pulse_req(8'h40);
    chk("R7 lower blocked", irq_o, 0);
    pulse_req(8'h04);
    chk("R7 higher raised", irq_o, 1);
    chk("R7 higher vec", vec_o, 2);
    do_ack();
    chk("R7 nested level", cur_lvl_o, 3);
    do_eoi();
    chk("R10 pop1 level", cur_lvl_o, 5);
    chk("R7 still blocked", irq_o, 0);
    do_eoi();
    chk("R10 pop2 level", cur_lvl_o, 9);
    chk("R7 deferred raised", irq_o, 1);
    chk("R7 deferred vec", vec_o, 6);

    // R10 empty pop
    do_reset();
    do_eoi();
    chk("R10 err pulse", err_o, 1);
    chk("R10 level kept", cur_lvl_o, 9);
    @(negedge clk);
    chk("R10 err one cycle", err_o, 0);

    // R12 software pend, pending cleared on ack (R9)
    do_reset();
    wr(SEL_ENABLE, 8'hFF);
    wr(SEL_GIE, 8'h01);
    wr(SEL_SWPEND, 8'h20);
    chk("R12 sw irq", irq_o, 1);
    chk("R12 sw vec", vec_o, 5);
    do_ack();
    do_eoi();
    chk("R9 pend cleared", irq_o, 0);

    // R11 stack full
    do_reset();
    wr(SEL_ENABLE, 8'hFF);
    for (int s = 7; s >= 4; s--) begin
      wr(SEL_GIE, 8'h01);
      wr(SEL_SWPEND, 8'(1 << s));
      do_ack();
    end
    chk("R11 level src4", cur_lvl_o, 5);
    wr(SEL_GIE, 8'h01);
    wr(SEL_SWPEND, 8'h08);
    chk("R11 full blocks", irq_o, 0);
    do_eoi();
    chk("R11 after pop level", cur_lvl_o, 6);
    chk("R11 after pop irq", irq_o, 1);
    chk("R11 after pop vec", vec_o, 3);

    // R13 stray acknowledge
    do_reset();
    wr(SEL_GIE, 8'h01);
    do_ack();
    chk("R13 level", cur_lvl_o, 9);
    chk("R13 gie", gie_o, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule